// File: doc/BRIEF.md
# Truncated Fixed-Point Product Accumulator

This block keeps a running sum of products of single-precision floating-point operand pairs. The sum is held in a short two's-complement fixed-point register, not in a floating-point adder. Each time the step strobe is high, the two operands are multiplied exactly from their full significands. The product is placed by the sum of its exponents and cut down to a window that runs from weight 2^4 to weight 2^-6, with two guard bits above the window. The aligned product is then added into the register through a carry chain built from fixed-width chunks. Anything finer than 2^-6 is lost. Anything too large for the register saturates it and raises a sticky overflow flag.

A seed strobe loads a single-precision value, cut to the same window, straight into the register. This is how a new dot product starts from an initial value. The result port always carries the register's contents converted back to single precision. A typical use is a short dot-product loop: load the seed, step once per element pair, then read the result.

Top module: `trunc_fx_accum`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) clears the sum to zero and the flag to 0. Afterwards result reads 0x00000000 and ovf_flag reads 0.
- R2: When step is high at an edge, the exact product op_x*op_y is added to the sum in units of 2^-6. The product's magnitude is truncated toward zero at that unit before it is added.
- R3: When neither step nor seed_load is high at an edge, the sum and the flag keep their values.
- R4: When seed_load is high at an edge, op_x is truncated toward zero to the 2^-6 unit, with its sign applied, and it replaces the sum. The flag is overwritten with that seed's own overflow status. A step in the same cycle is ignored.
- R5: An operand whose exponent field (bits 30:23) is 0, whether zero or subnormal, makes the step change nothing, even when the other operand is infinite or NaN. A seed with exponent field 0 loads zero.
- R6: If the operand sign bits (bit 31) differ, the product's magnitude is subtracted from the sum instead of added.
- R7: If a product or a seed has a magnitude of 2^13 units (128.0) or more, or has an operand whose exponent field is 255, the sum saturates and ovf_flag is set. It goes to +8191 units (0x42FFF800) for a positive sign and to -8192 units (0xC3000000) for a negative sign.
- R8: If adding an in-range product takes the sum beyond +8191 or below -8192 units, the sum saturates to the limit on that side and ovf_flag is set.
- R9: Once set, ovf_flag stays high until a reset or a seed load.
- R10: result is the single-precision encoding of the sum: sign in bit 31, exponent biased by 127 in bits 30:23, fraction in bits 22:0. It follows the register combinationally. A zero sum reads 0x00000000 and never negative zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Replace the sum with op_x cut to the window |
| step | input | 1 | Add op_x*op_y to the sum |
| op_x | input | 32 | First operand, single precision; also the seed value |
| op_y | input | 32 | Second operand, single precision |
| result | output | 32 | Current sum in single precision |
| ovf_flag | output | 1 | Sticky saturation flag |

## Verification
The clocked properties check on every cycle that an idle cycle or a zero operand leaves the register untouched. They also check that a product or sum overflow always lands on one of the two saturation limits with the flag raised, and that the flag cannot drop without a seed or a reset. The converter's immediate check confirms that it never emits a subnormal or negative-zero code. Only the scenarios can show the actual arithmetic: exact products, truncation just below 2^-6, subtraction for mixed signs, seed priority over a step in the same cycle, and the bit patterns of the converted results. The bench compares each of these against its own real-number model.

// File: rtl/trunc_fx_pkg.sv
package trunc_fx_pkg;

    localparam int FP_EXP_W  = 8;
    localparam int FP_FRAC_W = 23;
    localparam int FP_BIAS   = 127;
    localparam int FP_SIG_W  = FP_FRAC_W + 1;

    typedef struct packed {
        logic                 sign;
        logic [FP_EXP_W-1:0]  exp;
        logic [FP_FRAC_W-1:0] frac;
    } fp32_t;

endpackage

// File: rtl/fx_prod_align.sv
// Exact significand product, placed by exponent sum into the fixed window.
module fx_prod_align
    import trunc_fx_pkg::*;
#(
    parameter int LSB_FRAC = 6,
    parameter int MAG_W    = 13
) (
    input  logic [31:0]      a_i,
    input  logic [31:0]      b_i,
    output logic             zero_o,
    output logic             ovf_o,
    output logic             neg_o,
    output logic [MAG_W-1:0] mag_o
);
    localparam int PROD_W = 2 * FP_SIG_W;
    // right-shift count is PT_OFS minus the two biased exponents
    localparam int PT_OFS = 2 * FP_BIAS + 2 * FP_FRAC_W - LSB_FRAC;

    fp32_t              fa, fb;
    logic [PROD_W-1:0]  prod, shifted;
    int                 sh;

    assign fa = a_i;
    assign fb = b_i;

    always_comb begin
        prod    = PROD_W'({1'b1, fa.frac}) * PROD_W'({1'b1, fb.frac});
        sh      = PT_OFS - int'(fa.exp) - int'(fb.exp);
        shifted = (sh > 0) ? (prod >> sh) : '0;
        zero_o  = (fa.exp == '0) || (fb.exp == '0);
        neg_o   = fa.sign ^ fb.sign;
        ovf_o   = 1'b0;
        mag_o   = '0;
        if (!zero_o) begin
            if ((&fa.exp) || (&fb.exp) || (sh <= 0) || (|shifted[PROD_W-1:MAG_W])) begin
                ovf_o = 1'b1;
            end else begin
                mag_o = shifted[MAG_W-1:0];
            end
        end
    end

endmodule

// File: rtl/fx_seed_align.sv
// Single operand cut to the fixed window for the seed path.
module fx_seed_align
    import trunc_fx_pkg::*;
#(
    parameter int LSB_FRAC = 6,
    parameter int MAG_W    = 13
) (
    input  logic [31:0]      v_i,
    output logic             zero_o,
    output logic             ovf_o,
    output logic             neg_o,
    output logic [MAG_W-1:0] mag_o
);
    localparam int PT_OFS = FP_BIAS + FP_FRAC_W - LSB_FRAC;

    fp32_t                fv;
    logic [FP_SIG_W-1:0]  shifted;
    int                   sh;

    assign fv = v_i;

    always_comb begin
        sh      = PT_OFS - int'(fv.exp);
        shifted = (sh > 0) ? ({1'b1, fv.frac} >> sh) : '0;
        zero_o  = (fv.exp == '0);
        neg_o   = fv.sign;
        ovf_o   = 1'b0;
        mag_o   = '0;
        if (!zero_o) begin
            if ((&fv.exp) || (sh <= 0) || (|shifted[FP_SIG_W-1:MAG_W])) begin
                ovf_o = 1'b1;
            end else begin
                mag_o = shifted[MAG_W-1:0];
            end
        end
    end

endmodule

// File: rtl/fx_chunk_add.sv
// Signed adder with the carry rippling between fixed-width chunks.
module fx_chunk_add #(
    parameter int W     = 14,
    parameter int CHUNK = 16
) (
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    output logic [W-1:0]        sum_o,
    output logic                ovf_o,
    output logic                neg_o
);
    // one spare bit above W so the exact sum always fits
    localparam int NCH = (W + CHUNK) / CHUNK;
    localparam int PW  = NCH * CHUNK;

    logic [PW-1:0]  a_x, b_x, s_x;
    logic [NCH-1:0] cy;

    assign a_x   = PW'(a_i);
    assign b_x   = PW'(b_i);
    assign cy[0] = 1'b0;

    for (genvar g = 0; g < NCH; g++) begin : g_chunk
        if (g < NCH - 1) begin : g_mid
            logic [CHUNK:0] part;
            assign part = {1'b0, a_x[g*CHUNK +: CHUNK]} + {1'b0, b_x[g*CHUNK +: CHUNK]}
                        + (CHUNK+1)'(cy[g]);
            assign s_x[g*CHUNK +: CHUNK] = part[CHUNK-1:0];
            assign cy[g+1] = part[CHUNK];
        end else begin : g_top
            assign s_x[g*CHUNK +: CHUNK] = a_x[g*CHUNK +: CHUNK] + b_x[g*CHUNK +: CHUNK]
                                         + CHUNK'(cy[g]);
        end
    end

    assign sum_o = s_x[W-1:0];
    assign neg_o = s_x[PW-1];
    // result fits W bits only when all bits from W-1 upward agree
    assign ovf_o = !((&s_x[PW-1:W-1]) || !(|s_x[PW-1:W-1]));

endmodule

// File: rtl/fx_to_f32.sv
// Fixed-point register back to single precision (truncating).
module fx_to_f32
    import trunc_fx_pkg::*;
#(
    parameter int W        = 14,
    parameter int LSB_FRAC = 6
) (
    input  logic signed [W-1:0] acc_i,
    output logic [31:0]         res_o
);
    localparam int LW     = $clog2(W);
    localparam int WIDE_W = W + FP_FRAC_W;

    logic [W-1:0]      mag;
    logic [LW-1:0]     lead;
    logic [WIDE_W-1:0] wide;
    fp32_t             f;

    always_comb begin
        mag  = acc_i[W-1] ? W'(-acc_i) : W'(acc_i);
        lead = '0;
        for (int i = 0; i < W; i++) begin
            if (mag[i]) lead = LW'(i);
        end
        wide   = {mag, {FP_FRAC_W{1'b0}}};
        f.sign = acc_i[W-1];
        f.exp  = FP_EXP_W'(int'(lead) + FP_BIAS - LSB_FRAC);
        f.frac = wide[lead +: FP_FRAC_W];
        if (mag == '0) f = '0;
        res_o  = f;
    end

    always_comb begin
        if (!$isunknown(acc_i)) begin
            a_r10_no_subnormal_or_negzero: assert (res_o[30:23] != '0 || res_o == 32'h0)
                else $error("converter produced a subnormal or negative zero");
        end
    end

endmodule

// File: rtl/trunc_fx_accum.sv
module trunc_fx_accum
    import trunc_fx_pkg::*;
#(
    parameter int MSB_EXP    = 4,
    parameter int LSB_FRAC   = 6,
    parameter int GUARD_BITS = 2,
    parameter int CHUNK_W    = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        seed_load,
    input  logic        step,
    input  logic [31:0] op_x,
    input  logic [31:0] op_y,
    output logic [31:0] result,
    output logic        ovf_flag
);
    localparam int MAG_W = MSB_EXP + LSB_FRAC + 1 + GUARD_BITS;
    localparam int ACC_W = MAG_W + 1;
    localparam logic [ACC_W-1:0] SAT_POS = {1'b0, {MAG_W{1'b1}}};
    localparam logic [ACC_W-1:0] SAT_NEG = {1'b1, {MAG_W{1'b0}}};

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             ovf;
    } state_t;

    state_t state_d, state_q;

    logic             prod_zero, prod_ovf, prod_neg;
    logic [MAG_W-1:0] prod_mag;
    logic             seed_zero, seed_ovf, seed_neg;
    logic [MAG_W-1:0] seed_mag;
    logic signed [ACC_W-1:0] addend, seed_val;
    logic [ACC_W-1:0] add_sum;
    logic             add_ovf, add_neg;

    fx_prod_align #(.LSB_FRAC(LSB_FRAC), .MAG_W(MAG_W)) u_prod (
        .a_i(op_x), .b_i(op_y),
        .zero_o(prod_zero), .ovf_o(prod_ovf), .neg_o(prod_neg), .mag_o(prod_mag)
    );

    fx_seed_align #(.LSB_FRAC(LSB_FRAC), .MAG_W(MAG_W)) u_seed (
        .v_i(op_x),
        .zero_o(seed_zero), .ovf_o(seed_ovf), .neg_o(seed_neg), .mag_o(seed_mag)
    );

    assign addend   = prod_neg ? -$signed({1'b0, prod_mag}) : $signed({1'b0, prod_mag});
    assign seed_val = seed_neg ? -$signed({1'b0, seed_mag}) : $signed({1'b0, seed_mag});

    fx_chunk_add #(.W(ACC_W), .CHUNK(CHUNK_W)) u_add (
        .a_i($signed(state_q.acc)), .b_i(addend),
        .sum_o(add_sum), .ovf_o(add_ovf), .neg_o(add_neg)
    );

    fx_to_f32 #(.W(ACC_W), .LSB_FRAC(LSB_FRAC)) u_out (
        .acc_i($signed(state_q.acc)), .res_o(result)
    );

    always_comb begin
        state_d = state_q;
        if (seed_load) begin
            state_d.ovf = seed_ovf;
            if (seed_ovf)       state_d.acc = seed_neg ? SAT_NEG : SAT_POS;
            else if (seed_zero) state_d.acc = '0;
            else                state_d.acc = seed_val;
        end else if (step && !prod_zero) begin
            if (prod_ovf) begin
                state_d.acc = prod_neg ? SAT_NEG : SAT_POS;
                state_d.ovf = 1'b1;
            end else if (add_ovf) begin
                state_d.acc = add_neg ? SAT_NEG : SAT_POS;
                state_d.ovf = 1'b1;
            end else begin
                state_d.acc = add_sum;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign ovf_flag = state_q.ovf;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (state_q.acc == '0 && !state_q.ovf));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!seed_load && !step) |=> ($stable(state_q.acc) && $stable(state_q.ovf)));

    a_r5_zero_noop: assert property (@(posedge clk) disable iff (rst)
        (step && !seed_load && prod_zero) |=> ($stable(state_q.acc) && $stable(state_q.ovf)));

    a_r7_prod_saturates: assert property (@(posedge clk) disable iff (rst)
        (step && !seed_load && !prod_zero && prod_ovf)
        |=> (state_q.ovf && (state_q.acc == SAT_POS || state_q.acc == SAT_NEG)));

    a_r8_sum_saturates: assert property (@(posedge clk) disable iff (rst)
        (step && !seed_load && !prod_zero && !prod_ovf && add_ovf)
        |=> (state_q.ovf && (state_q.acc == SAT_POS || state_q.acc == SAT_NEG)));

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (state_q.ovf && !seed_load) |=> state_q.ovf);

endmodule

// File: tb/tb_trunc_fx_accum.sv
module tb_trunc_fx_accum;
    localparam int CLK_PERIOD = 10;
    localparam int LIM_POS = 8191;
    localparam int LIM_NEG = -8192;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seed_load = 1'b0;
    logic        step = 1'b0;
    logic [31:0] op_x = '0;
    logic [31:0] op_y = '0;
    logic [31:0] result;
    logic        ovf_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int m_acc = 0;
    bit m_ovf = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        ovf;
        string       tag;
    } item_t;
    item_t sb_q[$];

    trunc_fx_accum dut (
        .clk(clk), .rst(rst), .seed_load(seed_load), .step(step),
        .op_x(op_x), .op_y(op_y), .result(result), .ovf_flag(ovf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] f32(real r);
        logic [63:0] b;
        int e;
        if (r == 0.0) return 32'h0;
        b = $realtobits(r);
        e = int'(b[62:52]) - 1023 + 127;
        return {b[63], e[7:0], b[51:29]};
    endfunction

    function automatic real r_of(logic [31:0] v);
        int e;
        logic [63:0] b;
        if (v[30:23] == 8'h0) return 0.0;
        e = int'(v[30:23]) - 127 + 1023;
        b = {v[31], e[10:0], v[22:0], 29'h0};
        return $bitstoreal(b);
    endfunction

    function automatic logic [31:0] expect_res();
        if (m_acc == 0) return 32'h0;
        return f32(real'(m_acc) / 64.0);
    endfunction

    task automatic sat(bit neg);
        m_acc = neg ? LIM_NEG : LIM_POS;
        m_ovf = 1'b1;
    endtask

    task automatic model_step(logic [31:0] x, logic [31:0] y);
        real p, m;
        int add, s;
        bit neg;
        neg = x[31] ^ y[31];
        if (x[30:23] == 8'h0 || y[30:23] == 8'h0) return;
        if (x[30:23] == 8'hFF || y[30:23] == 8'hFF) begin sat(neg); return; end
        p = r_of(x) * r_of(y);
        m = (p < 0.0 ? -p : p) * 64.0;
        if (m >= 8192.0) begin sat(neg); return; end
        add = $rtoi(m);
        s = neg ? m_acc - add : m_acc + add;
        if (s > LIM_POS)      sat(1'b0);
        else if (s < LIM_NEG) sat(1'b1);
        else                  m_acc = s;
    endtask

    task automatic model_seed(logic [31:0] x);
        real m;
        m_ovf = 1'b0;
        if (x[30:23] == 8'h0) begin m_acc = 0; return; end
        if (x[30:23] == 8'hFF) begin sat(x[31]); return; end
        m = r_of(x); m = (m < 0.0 ? -m : m) * 64.0;
        if (m >= 8192.0) begin sat(x[31]); return; end
        m_acc = x[31] ? -$rtoi(m) : $rtoi(m);
    endtask

    task automatic push(string tag);
        item_t it;
        it.res = expect_res();
        it.ovf = m_ovf;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic do_op(bit sd, bit st, logic [31:0] x, logic [31:0] y, string tag);
        @(negedge clk);
        seed_load = sd; step = st; op_x = x; op_y = y;
        if (sd)      model_seed(x);
        else if (st) model_step(x, y);
        push(tag);
        @(posedge clk); #1;
        seed_load = 1'b0; step = 1'b0;
    endtask

    task automatic do_reset(string tag);
        @(negedge clk);
        rst = 1'b1;
        m_acc = 0; m_ovf = 1'b0;
        push(tag);
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    // monitor: one item per edge that had a pushed stimulus
    always @(posedge clk) begin
        item_t it;
        #2;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            n_checks++;
            if (result !== it.res || ovf_flag !== it.ovf) begin
                n_fail++;
                $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b",
                         it.tag, result, ovf_flag, it.res, it.ovf);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset("R1 reset state");
        do_op(0, 0, 32'h0, 32'h0, "R3 idle after reset");
        do_op(0, 1, f32(1.5), f32(2.5), "R2 basic product");
        do_op(0, 1, f32(0.1), f32(0.1), "R2 product below lsb truncated");
        do_op(0, 1, f32(0.015625), f32(1.0), "R2 product exactly one lsb");
        do_op(0, 1, f32(0.0078125), f32(1.0), "R2 half lsb dropped");
        do_op(0, 0, f32(9.0), f32(9.0), "R3 idle hold with live operands");
        do_op(0, 1, f32(-2.0), f32(3.0), "R6 negative product subtracts");
        do_op(0, 1, f32(-1.25), f32(-0.5), "R6 two negatives add");
        do_op(0, 1, 32'h0, f32(5.0), "R5 zero operand");
        do_op(0, 1, 32'h0000_0001, f32(2.0**100), "R5 subnormal operand");
        do_op(0, 1, 32'h8000_0000, 32'h7F80_0000, "R5 zero times infinity");
        do_op(1, 0, f32(10.3), 32'h0, "R4 seed truncated");
        do_op(1, 1, f32(1.0), f32(4.0), "R4 seed wins over step");
        do_op(0, 1, f32(1.0), f32(-1.0), "R10 cancel to positive zero");
        do_op(0, 1, f32(100.0), f32(2.0), "R7 product overflow saturates");
        do_op(0, 1, f32(-1.0), f32(1.0), "R9 flag sticky after later step");
        do_op(0, 0, 32'h0, 32'h0, "R9 flag sticky when idle");
        do_op(1, 0, f32(100.0), 32'h0, "R4 seed clears flag");
        do_op(0, 1, f32(30.0), f32(1.0), "R8 sum overflow positive");
        do_op(1, 0, f32(-100.0), 32'h0, "R4 negative seed");
        do_op(0, 1, f32(-20.0), f32(2.0), "R8 sum overflow negative");
        do_op(1, 0, 32'h7F80_0000, 32'h0, "R7 infinite seed");
        do_op(1, 0, f32(-200.0), 32'h0, "R7 large negative seed");
        do_op(1, 0, f32(0.5), 32'h0, "R4 seed in range");
        do_op(0, 1, 32'h7FC0_0000, f32(1.0), "R7 NaN operand");
        do_op(1, 0, f32(-0.75), 32'h0, "R10 negative value encoding");
        do_op(0, 1, f32(3.0), f32(0.3), "R10 mixed fraction encoding");
        do_reset("R1 reset mid run");
        do_op(0, 0, 32'h0, 32'h0, "R1 held after reset");
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule